// File: doc/BRIEF.md
# Bridge IO Forwarding Window Decoder

This block is the IO-window slice of a PCI-to-PCI style bridge's configuration space, together with the address decoder that uses it. Software programs an IO base and an IO limit register (each holding address bits [15:12] in its upper nibble), two 16-bit upper-address registers that carry bits [31:16], and an IO enable bit in the command register. These go through a simple configuration write port, and a read port returns the programmed values.

Each incoming IO transaction presents an address with a valid strobe. One cycle later the decoder raises `claim_o` if the bridge should forward that address. The window is open from `{base_up, base_nib, 12'h000}` through `{limit_up, limit_nib, 12'hFFF}`, so it has 4 KB granularity and a base equal to the limit still opens one 4 KB region. The window is closed only when the limit is below the base or when IO is disabled.

A parameter removes IO support entirely. In that case every window register reads zero, writes to them are ignored, and nothing is ever claimed.

Top module: `io_win_decoder`

## Requirements
- R1: The decode has 4 KB granularity. Bits [7:4] of the base and limit bytes give address bits [15:12], and address bits [11:0] never affect the claim. For example, base 0x20 with limit 0x50 claims every address from 0x2000 through 0x5FFF and does not claim 0x6000.
- R2: When the 32-bit limit `{limit_up, limit[7:4]}` is strictly below the 32-bit base `{base_up, base[7:4]}`, no address is claimed. For example, base byte 0xF0 with limit byte 0x00 and both upper registers zero claims neither 0xF000 nor 0x0000.
- R3: When base equals limit, exactly one 4 KB region is claimed. With both bytes 0xF0, the addresses 0xF000 and 0xFFFF are claimed and 0xEFFF is not.
- R4: Base and limit both 0x00, with the upper registers zero, opens the window 0x0000–0x0FFF. It does not close the window.
- R5: While the command IO enable bit (command register bit 0) is 0, nothing is claimed, whatever the window registers hold.
- R6: The comparison uses all 32 address bits, with the upper registers supplying bits [31:16]. An address whose upper half lies outside the range set by the upper registers is not claimed, even if its low 16 bits match.
- R7: Bits [3:0] of the base and limit readback are read-only and read 0x1 when IO is supported, which advertises 32-bit IO. Writes to those bits have no effect.
- R8: `claim_o` is registered. It reflects the address presented with `addr_valid_i` at the previous rising edge, and it is 0 after any cycle in which `addr_valid_i` was low.
- R9: A configuration write takes effect on the comparison that follows it. A write in the same cycle as a valid address does not change the result for that address.
- R10: After reset the window registers hold zero (base and limit read 0x0001), the command register reads 0, and `claim_o` is 0.
- R11: With `IO_SUPPORT` = 0, every window register and the command register read zero, writes to them are ignored, and `claim_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wsel_i | input | 3 | Write register select: 0 base byte, 1 limit byte, 2 base upper, 3 limit upper, 4 command |
| cfg_wdata_i | input | 16 | Write data; the byte registers use [7:0] and the command register uses bit 0 |
| cfg_rsel_i | input | 3 | Read register select, with the same encoding as the write select |
| cfg_rdata_o | output | 16 | Readback of the selected register, zero-extended; unmapped selects read 0 |
| addr_valid_i | input | 1 | IO transaction address strobe |
| addr_i | input | 32 | IO transaction address |
| claim_o | output | 1 | Forward/claim decision, one cycle after the strobe |

## Verification
On every cycle, assertions check that a claim only follows a cycle in which a valid address was presented, IO was enabled, the window was not inverted, and the address lay between base and limit. They also check that a write to the base or limit byte reaches the decoder on the next edge.

The exact 4 KB edges, the 0x00/0x00 case, and the upper-half decode need concrete address patterns, so the bench's vector table covers them. The bench's directed cases cover the read-only nibble, the old-value result when a write and a lookup share an edge, and the variant built without IO support.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
  typedef enum logic [2:0] {
    SEL_BASE     = 3'd0,
    SEL_LIMIT    = 3'd1,
    SEL_BASE_UP  = 3'd2,
    SEL_LIMIT_UP = 3'd3,
    SEL_CMD      = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/io_win_regs.sv
module io_win_regs
  import io_win_pkg::*;
#(
  parameter bit          IO_SUPPORT = 1'b1,
  parameter int unsigned UP_W       = 16,
  parameter int unsigned NIB_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  cfg_sel_e         wsel_i,
  input  logic [UP_W-1:0]  wdata_i,
  input  cfg_sel_e         rsel_i,
  output logic [UP_W-1:0]  rdata_o,
  output logic [NIB_W-1:0] base_nib_o,
  output logic [NIB_W-1:0] limit_nib_o,
  output logic [UP_W-1:0]  base_up_o,
  output logic [UP_W-1:0]  limit_up_o,
  output logic             io_en_o
);
  localparam int unsigned BYTE_W = 2 * NIB_W;
  localparam logic [NIB_W-1:0] CAP32 = NIB_W'(1);

  logic [BYTE_W-1:0] base_rd, limit_rd;

  generate
    if (IO_SUPPORT) begin : g_io
      logic [NIB_W-1:0] base_q, limit_q;
      logic [UP_W-1:0]  base_up_q, limit_up_q;
      logic             io_en_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_q     <= '0;
          limit_q    <= '0;
          base_up_q  <= '0;
          limit_up_q <= '0;
          io_en_q    <= 1'b0;
        end else if (we_i) begin
          unique case (wsel_i)
            SEL_BASE:     base_q     <= wdata_i[BYTE_W-1:NIB_W];
            SEL_LIMIT:    limit_q    <= wdata_i[BYTE_W-1:NIB_W];
            SEL_BASE_UP:  base_up_q  <= wdata_i;
            SEL_LIMIT_UP: limit_up_q <= wdata_i;
            SEL_CMD:      io_en_q    <= wdata_i[0];
            default: ;
          endcase
        end
      end

      assign base_nib_o  = base_q;
      assign limit_nib_o = limit_q;
      assign base_up_o   = base_up_q;
      assign limit_up_o  = limit_up_q;
      assign io_en_o     = io_en_q;
      assign base_rd     = {base_q, CAP32};
      assign limit_rd    = {limit_q, CAP32};

      // R9
      base_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && wsel_i == SEL_BASE) |=> base_nib_o == $past(wdata_i[BYTE_W-1:NIB_W]));
      // R9
      limit_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && wsel_i == SEL_LIMIT) |=> limit_nib_o == $past(wdata_i[BYTE_W-1:NIB_W]));
    end else begin : g_no_io
      // registers hard-wired to zero, writes dropped
      assign base_nib_o  = '0;
      assign limit_nib_o = '0;
      assign base_up_o   = '0;
      assign limit_up_o  = '0;
      assign io_en_o     = 1'b0;
      assign base_rd     = '0;
      assign limit_rd    = '0;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    unique case (rsel_i)
      SEL_BASE:     rdata_o = UP_W'(base_rd);
      SEL_LIMIT:    rdata_o = UP_W'(limit_rd);
      SEL_BASE_UP:  rdata_o = base_up_o;
      SEL_LIMIT_UP: rdata_o = limit_up_o;
      SEL_CMD:      rdata_o = UP_W'(io_en_o);
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/io_win_cmp.sv
module io_win_cmp #(
  parameter int unsigned UP_W   = 16,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned GRAN_W = 12,
  localparam int unsigned PG_W   = UP_W + NIB_W,
  localparam int unsigned ADDR_W = PG_W + GRAN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  base_nib_i,
  input  logic [NIB_W-1:0]  limit_nib_i,
  input  logic [UP_W-1:0]   base_up_i,
  input  logic [UP_W-1:0]   limit_up_i,
  input  logic              io_en_i,
  output logic              claim_o
);
  logic [ADDR_W-1:0] lo_addr, hi_addr;
  logic              hit, claim_q;

  assign lo_addr = {base_up_i, base_nib_i, {GRAN_W{1'b0}}};
  assign hi_addr = {limit_up_i, limit_nib_i, {GRAN_W{1'b1}}};
  // inverted window gives lo > hi, so no address satisfies both bounds
  assign hit = (addr_i >= lo_addr) && (addr_i <= hi_addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) claim_q <= 1'b0;
    else         claim_q <= valid_i && io_en_i && hit;
  end

  assign claim_o = claim_q;

  // R5
  io_en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> $past(io_en_i));
  // R8
  claim_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> $past(valid_i));
  // R2
  inverted_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> ($past({limit_up_i, limit_nib_i}) >= $past({base_up_i, base_nib_i})));
  // R1
  page_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> ($past(addr_i[ADDR_W-1:GRAN_W]) >= $past({base_up_i, base_nib_i}) &&
                 $past(addr_i[ADDR_W-1:GRAN_W]) <= $past({limit_up_i, limit_nib_i})));
endmodule

// File: rtl/io_win_decoder.sv
module io_win_decoder
  import io_win_pkg::*;
#(
  parameter bit          IO_SUPPORT = 1'b1,
  parameter int unsigned UP_W       = 16,
  parameter int unsigned NIB_W      = 4,
  parameter int unsigned GRAN_W     = 12,
  localparam int unsigned ADDR_W    = UP_W + NIB_W + GRAN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_wsel_i,
  input  logic [UP_W-1:0]   cfg_wdata_i,
  input  logic [2:0]        cfg_rsel_i,
  output logic [UP_W-1:0]   cfg_rdata_o,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              claim_o
);
  logic [NIB_W-1:0] base_nib, limit_nib;
  logic [UP_W-1:0]  base_up, limit_up;
  logic             io_en;

  io_win_regs #(
    .IO_SUPPORT(IO_SUPPORT),
    .UP_W      (UP_W),
    .NIB_W     (NIB_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wsel_i     (cfg_sel_e'(cfg_wsel_i)),
    .wdata_i    (cfg_wdata_i),
    .rsel_i     (cfg_sel_e'(cfg_rsel_i)),
    .rdata_o    (cfg_rdata_o),
    .base_nib_o (base_nib),
    .limit_nib_o(limit_nib),
    .base_up_o  (base_up),
    .limit_up_o (limit_up),
    .io_en_o    (io_en)
  );

  io_win_cmp #(
    .UP_W  (UP_W),
    .NIB_W (NIB_W),
    .GRAN_W(GRAN_W)
  ) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (addr_valid_i),
    .addr_i     (addr_i),
    .base_nib_i (base_nib),
    .limit_nib_i(limit_nib),
    .base_up_i  (base_up),
    .limit_up_i (limit_up),
    .io_en_i    (io_en),
    .claim_o    (claim_o)
  );
endmodule

// File: tb/sim_io_win_decoder.sv
`timescale 1ns/1ps
module sim_io_win_decoder;
  localparam int NV = 15;
  // {base byte, limit byte, base upper, limit upper, address, expected claim}
  localparam logic [80:0] VEC [NV] = '{
    {8'hF0, 8'hF0, 16'h0000, 16'h0000, 32'h0000_F000, 1'b1},
    {8'hF0, 8'hF0, 16'h0000, 16'h0000, 32'h0000_EFFF, 1'b0},
    {8'hF0, 8'hF0, 16'h0000, 16'h0000, 32'h0000_FFFF, 1'b1},
    {8'h00, 8'h00, 16'h0000, 16'h0000, 32'h0000_0000, 1'b1},
    {8'h00, 8'h00, 16'h0000, 16'h0000, 32'h0000_0FFF, 1'b1},
    {8'h00, 8'h00, 16'h0000, 16'h0000, 32'h0000_1000, 1'b0},
    {8'hF0, 8'h00, 16'h0000, 16'h0000, 32'h0000_F000, 1'b0},
    {8'hF0, 8'h00, 16'h0000, 16'h0000, 32'h0000_0000, 1'b0},
    {8'h20, 8'h50, 16'h0000, 16'h0000, 32'h0000_3ABC, 1'b1},
    {8'h20, 8'h50, 16'h0000, 16'h0000, 32'h0000_5FFF, 1'b1},
    {8'h20, 8'h50, 16'h0000, 16'h0000, 32'h0000_6000, 1'b0},
    {8'h20, 8'h50, 16'h0001, 16'h0001, 32'h0001_3000, 1'b1},
    {8'h20, 8'h50, 16'h0001, 16'h0001, 32'h0000_3000, 1'b0},
    {8'h20, 8'h50, 16'h0001, 16'h0002, 32'h0001_8000, 1'b1},
    {8'h50, 8'h20, 16'h0001, 16'h0002, 32'h0002_0000, 1'b1}
  };
  localparam string VREQ [NV] = '{"R3", "R3", "R3", "R4", "R4", "R4", "R2", "R2",
                                  "R1", "R1", "R1", "R6", "R6", "R6", "R6"};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  wsel = '0;
  logic [15:0] wdata = '0;
  logic [2:0]  rsel = '0;
  logic        valid = 1'b0;
  logic [31:0] addr = '0;
  logic [15:0] rdata0, rdata1;
  logic        claim0, claim1;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  io_win_decoder u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(we), .cfg_wsel_i(wsel),
    .cfg_wdata_i(wdata), .cfg_rsel_i(rsel), .cfg_rdata_o(rdata0),
    .addr_valid_i(valid), .addr_i(addr), .claim_o(claim0)
  );

  io_win_decoder #(.IO_SUPPORT(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(we), .cfg_wsel_i(wsel),
    .cfg_wdata_i(wdata), .cfg_rsel_i(rsel), .cfg_rdata_o(rdata1),
    .addr_valid_i(valid), .addr_i(addr), .claim_o(claim1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; wsel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s);
    @(negedge clk);
    rsel = s;
    #1;
  endtask

  // presents one address; returns with claim outputs settled for it
  task automatic probe(input logic [31:0] a);
    @(negedge clk);
    valid = 1'b1; addr = a;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;

    // R10 reset state
    rd(3'd0); check("R10 base", 32'(rdata0), 32'h0001);
    rd(3'd1); check("R10 limit", 32'(rdata0), 32'h0001);
    rd(3'd4); check("R10 cmd", 32'(rdata0), 32'h0);
    check("R10 claim", 32'(claim0), 32'h0);

    // R5 window open but IO disabled
    cfg_wr(3'd0, 16'h00F0); cfg_wr(3'd1, 16'h00F0);
    probe(32'h0000_F000); check("R5 disabled", 32'(claim0), 32'h0);
    cfg_wr(3'd4, 16'h0001);

    // table walk
    for (int i = 0; i < NV; i++) begin
      cfg_wr(3'd0, {8'h00, VEC[i][80:73]});
      cfg_wr(3'd1, {8'h00, VEC[i][72:65]});
      cfg_wr(3'd2, VEC[i][64:49]);
      cfg_wr(3'd3, VEC[i][48:33]);
      probe(VEC[i][32:1]);
      check(VREQ[i], 32'(claim0), 32'(VEC[i][0]));
    end

    // R7 low nibble read-only
    cfg_wr(3'd0, 16'h003F);
    rd(3'd0); check("R7 base nibble", 32'(rdata0), 32'h0031);
    cfg_wr(3'd1, 16'h005E);
    rd(3'd1); check("R7 limit nibble", 32'(rdata0), 32'h0051);

    // R8 registered claim, no strobe means no claim
    cfg_wr(3'd0, 16'h0020); cfg_wr(3'd1, 16'h0050);
    cfg_wr(3'd2, 16'h0000); cfg_wr(3'd3, 16'h0000);
    @(negedge clk); valid = 1'b0; addr = 32'h0000_3000;
    @(negedge clk); check("R8 no strobe", 32'(claim0), 32'h0);
    valid = 1'b1;
    #1; check("R8 not combinational", 32'(claim0), 32'h0);
    @(negedge clk); valid = 1'b0;
    check("R8 one cycle", 32'(claim0), 32'h1);
    @(negedge clk); check("R8 drops", 32'(claim0), 32'h0);

    // R9 write and lookup on the same edge use the old window
    @(negedge clk);
    we = 1'b1; wsel = 3'd0; wdata = 16'h0060;
    valid = 1'b1; addr = 32'h0000_3000;
    @(negedge clk);
    we = 1'b0; valid = 1'b0;
    check("R9 old value", 32'(claim0), 32'h1);
    probe(32'h0000_3000); check("R9 new value", 32'(claim0), 32'h0);

    // R11 variant without IO
    rd(3'd0); check("R11 base reads zero", 32'(rdata1), 32'h0);
    rd(3'd3); check("R11 upper reads zero", 32'(rdata1), 32'h0);
    rd(3'd4); check("R11 cmd reads zero", 32'(rdata1), 32'h0);
    cfg_wr(3'd0, 16'h0000); cfg_wr(3'd1, 16'h0000);
    probe(32'h0000_0000); check("R11 no claim", 32'(claim1), 32'h0);
    check("R4 zero window", 32'(claim0), 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule